// File: doc/BRIEF.md
# Serially Configured Lookup-Table Logic Cell

This block is one programmable logic cell. A 16-entry truth table, addressed by four user inputs, gives one output bit. The output can come straight from the table or from a flip-flop that samples the table result on the user clock. The table and two mode bits sit in one configuration shift register. That register loads one bit per clock while the configuration enable is high. Its last stage drives a serial output, so several cells can be loaded in a daisy chain from one bitstream.

When the RAM mode bit is set, the table also works as a 16x1 memory. The four inputs become the address. The read is combinational, and a write enable with a data bit updates the addressed entry on the rising clock edge.

Top module: `lut_cell`

## Requirements
- R1: With input value k on `lin` (k = 0 for 0000 up to 15 for 1111), the table result is table bit k. Bit 0 is the first entry and bit 15 is the last.
- R2: Any of the 65,536 possible 16-bit tables can be loaded and is reproduced exactly. Examples are a two-input AND on `lin[1:0]` (16'h8888) and a two-input OR (16'hEEEE).
- R3: The configuration chain is 18 bits long, and each enabled clock shifts `cfg_din` into chain position 0. The bits of one cell's stream are sent in this order: RAM-mode bit, then output-select bit, then table bits 15 down to 0. `cfg_dout` is the last chain bit, which after a full load is the RAM-mode bit.
- R4: When `cfg_dout` of one cell drives `cfg_din` of a second cell, 36 shifts load both cells. The far cell's 18 bits are sent first.
- R5: With the output-select bit at 0 and configuration idle, `lout` equals the table result for the current `lin` in the same cycle.
- R6: With the output-select bit at 1, `lout` shows the table result for the `lin` value that was present at the previous rising clock edge.
- R7: While `cfg_en` is high, `lout` is 0 and the output flip-flop keeps its value.
- R8: With the RAM-mode bit at 1 and `wr_en` high while configuration is idle, the rising clock edge writes `wr_data` into table bit `lin`. The asynchronous read then returns that value.
- R9: With the RAM-mode bit at 0, `wr_en` has no effect on the table contents.
- R10: `rst_n` low at a rising clock edge clears the output flip-flop and leaves every configuration bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration shifts, the output flip-flop and RAM writes |
| rst_n | input | 1 | Synchronous active-low reset of the output flip-flop |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (last chain stage) |
| lin | input | AW (4) | Logic inputs; the RAM address in RAM mode |
| wr_en | input | 1 | RAM write enable |
| wr_data | input | 1 | RAM write data |
| lout | output | 1 | Cell output |

## Verification
The bench builds two cells with the default address width of 4, which keeps every truth-table index reachable. That width lets the bench sweep all 16 input codes exhaustively for each loaded table, in both output modes. Joining the two cells through the serial port makes the 36-bit daisy-chain load and the serial-out order visible at the pins. The RAM part fills and rewrites all 16 addresses, and compares each write against a non-RAM cell where the same writes must leave the table unchanged.

// File: rtl/lut_cell_pkg.sv
// Package: shared constants and types for the lookup-table cell.
// Assumes the two mode bits sit directly above the table bits in the chain.
package lut_cell_pkg;
    localparam int MODE_BITS = 2;

    // Mode bits in chain order: ram_en is the highest chain bit
    typedef struct packed {
        logic ram_en;
        logic reg_out;
    } cell_mode_t;

    // Total configuration chain length for an address width
    function automatic int chain_len(input int aw);
        return (1 << aw) + MODE_BITS;
    endfunction
endpackage

// File: rtl/lut_cfg_store.sv
// Configuration storage: one shift chain that holds the table bits and
// the mode bits. Also takes user writes to the table bits in RAM mode.
// Assumes cfg_en has priority over user writes.
module lut_cfg_store
    import lut_cell_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                clk,
    input  logic                cfg_en,
    input  logic                cfg_din,
    output logic                cfg_dout,
    input  logic [AW-1:0]       addr,
    input  logic                wr_en,
    input  logic                wr_data,
    output logic [(1<<AW)-1:0]  table_o,
    output cell_mode_t          mode_o
);
    localparam int DEPTH = 1 << AW;
    localparam int CHAIN = chain_len(AW);

    logic [CHAIN-1:0] chain_q;
    logic             wr_ok;

    // A user write is allowed only in RAM mode and when configuration is idle
    assign wr_ok = !cfg_en && chain_q[CHAIN-1] && wr_en;

    // Shift the chain when configuring, otherwise apply a RAM write
    always_ff @(posedge clk) begin
        if (cfg_en) begin
            chain_q <= {chain_q[CHAIN-2:0], cfg_din};
        end else if (wr_ok) begin
            chain_q[addr] <= wr_data;
        end
    end

    // Split the chain into its fields
    assign table_o  = chain_q[DEPTH-1:0];
    assign mode_o   = cell_mode_t'(chain_q[CHAIN-1:DEPTH]);
    assign cfg_dout = chain_q[CHAIN-1];
endmodule

// File: rtl/lut_sel.sv
// Table read: a 2**AW-to-1 selector driven by the logic inputs.
// Purely combinational; input value k selects table bit k.
module lut_sel #(
    parameter int AW = 4
) (
    input  logic [(1<<AW)-1:0] table_i,
    input  logic [AW-1:0]      addr,
    output logic               bit_o
);
    // Select the addressed table entry
    assign bit_o = table_i[addr];
endmodule

// File: rtl/lut_out_stage.sv
// Output stage: optional flip-flop plus output selector.
// Assumes a synchronous active-low reset; holds the flip-flop and forces
// the output low while configuration is shifting.
module lut_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic reg_out,
    input  logic d,
    output logic q
);
    logic ff_q;

    // Capture the table result unless reset or configuring
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q <= 1'b0;
        end else if (!cfg_en) begin
            ff_q <= d;
        end
    end

    // Pick registered or direct result; output is low during configuration
    always_comb begin
        if (cfg_en) begin
            q = 1'b0;
        end else if (reg_out) begin
            q = ff_q;
        end else begin
            q = d;
        end
    end
endmodule

// File: rtl/lut_cell.sv
// Top: serially configured lookup-table logic cell with optional output
// flip-flop and a RAM mode. Assumes one clock for both configuration and
// user logic.
module lut_cell
    import lut_cell_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic          cfg_din,
    output logic          cfg_dout,
    input  logic [AW-1:0] lin,
    input  logic          wr_en,
    input  logic          wr_data,
    output logic          lout
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] table_w;
    cell_mode_t       mode_w;
    logic             lut_bit;

    lut_cfg_store #(.AW(AW)) u_store (
        .clk      (clk),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_dout (cfg_dout),
        .addr     (lin),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .table_o  (table_w),
        .mode_o   (mode_w)
    );

    lut_sel #(.AW(AW)) u_sel (
        .table_i (table_w),
        .addr    (lin),
        .bit_o   (lut_bit)
    );

    lut_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .reg_out (mode_w.reg_out),
        .d       (lut_bit),
        .q       (lout)
    );
endmodule

// File: rtl/lut_cell_chk.sv
// Checker: temporal properties of the lookup-table cell, bound to the top.
module lut_cell_chk #(
    parameter int AW = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_en,
    input logic                cfg_din,
    input logic [AW-1:0]       lin,
    input logic                wr_en,
    input logic                wr_data,
    input logic                lout,
    input logic [(1<<AW)-1:0]  tbl,
    input logic                reg_out,
    input logic                ram_en
);
    AST_CFG_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> lout == 1'b0);  // R7

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> tbl[0] == $past(cfg_din));  // R3

    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !(ram_en && wr_en)) |=> $stable(tbl));  // R9

    AST_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && ram_en && wr_en) |=> tbl[$past(lin)] == $past(wr_data));  // R8

    AST_REG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_en) && !cfg_en && reg_out)
            |-> lout == $past(tbl[lin]));  // R6

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !$past(cfg_en) && !cfg_en && reg_out) |-> lout == 1'b0);  // R10
endmodule

bind lut_cell lut_cell_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .lin     (lin),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .lout    (lout),
    .tbl     (table_w),
    .reg_out (mode_w.reg_out),
    .ram_en  (mode_w.ram_en)
);

// File: tb/lut_cell_bench.sv
// Bench: two daisy-chained cells, exhaustive input sweeps per table.
module lut_cell_bench;
    localparam int AW    = 4;
    localparam int DEPTH = 16;
    localparam int CFG   = DEPTH + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic          cfg_din = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_data = 1'b0;
    logic [AW-1:0] lin = '0;
    logic          mid, tail_dout, lout_a, lout_b;
    int            n_vec = 0;
    int            n_bad = 0;

    always #5 clk = ~clk;

    lut_cell #(.AW(AW)) u_lut_cell (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_dout(mid), .lin(lin), .wr_en(wr_en), .wr_data(wr_data),
        .lout(lout_a)
    );

    lut_cell #(.AW(AW)) u_tail (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(mid),
        .cfg_dout(tail_dout), .lin(lin), .wr_en(wr_en), .wr_data(wr_data),
        .lout(lout_b)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [CFG-1:0] mk(input logic ram, input logic rsel,
                                          input logic [DEPTH-1:0] t);
        return {ram, rsel, t};
    endfunction

    // Load both cells: far cell's bits first, MSB of each config first (R3, R4)
    task automatic load_pair(input logic [CFG-1:0] ca, input logic [CFG-1:0] cb);
        logic [2*CFG-1:0] stream;
        stream = {cb, ca};
        cfg_en = 1'b1;
        for (int i = 2*CFG-1; i >= 0; i--) begin
            cfg_din = stream[i];
            step();
            chk(lout_a, 1'b0, "R7 output low while shifting");
        end
        cfg_en = 1'b0;
        #1;
        chk(mid, ca[CFG-1], "R3 serial out is RAM-mode bit");
        chk(tail_dout, cb[CFG-1], "R4 far cell serial out");
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        logic [DEPTH-1:0] ta, tb, pat;
        cfg_en = 1'b1;
        repeat (3) step();
        chk(lout_a, 1'b0, "R7 reset state output low");
        cfg_en = 1'b0;
        rst_n  = 1'b1;
        step();

        // Table sweeps in both output modes (R1 R2 R4 R5 R6)
        for (int t = 0; t < 10; t++) begin
            if (t == 0) begin
                ta = 16'h8888;
                tb = 16'hEEEE;
            end else begin
                ta = DEPTH'($urandom);
                tb = DEPTH'($urandom);
            end
            load_pair(mk(1'b0, 1'b0, ta), mk(1'b0, 1'b0, tb));
            for (int k = 0; k < DEPTH; k++) begin
                lin = AW'(k);
                #1;
                chk(lout_a, ta[k], "R1 R2 R5 direct output");
                chk(lout_b, tb[k], "R4 R2 far cell direct output");
            end
            load_pair(mk(1'b0, 1'b1, ta), mk(1'b0, 1'b1, tb));
            for (int k = 0; k < DEPTH; k++) begin
                lin = AW'(k);
                #1;
                if (k > 0) chk(lout_a, ta[k-1], "R6 one-cycle latency");
                step();
                chk(lout_a, ta[k], "R6 registered output");
                chk(lout_b, tb[k], "R4 far cell registered output");
            end
        end

        // Reset clears flip-flop, keeps configuration (R10)
        load_pair(mk(1'b0, 1'b1, 16'hFFFF), mk(1'b0, 1'b0, 16'h0000));
        step();
        chk(lout_a, 1'b1, "R10 flip-flop loaded before reset");
        rst_n = 1'b0;
        step();
        chk(lout_a, 1'b0, "R10 reset clears flip-flop");
        rst_n = 1'b1;
        #1;
        chk(lout_a, 1'b0, "R10 cleared until next edge");
        step();
        chk(lout_a, 1'b1, "R10 configuration kept");

        // Writes ignored outside RAM mode (R9)
        ta = 16'h3C5A;
        load_pair(mk(1'b0, 1'b0, ta), mk(1'b1, 1'b0, 16'h0000));
        wr_en = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            lin = AW'(k);
            wr_data = ~ta[k];
            step();
        end
        wr_en = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            lin = AW'(k);
            #1;
            chk(lout_a, ta[k], "R9 table unchanged by writes");
            chk(lout_b, ~ta[k], "R8 far cell RAM write");
        end

        // RAM fill, read, rewrite (R8)
        pat = 16'hA6D1;
        load_pair(mk(1'b1, 1'b0, 16'h0000), mk(1'b1, 1'b0, 16'hFFFF));
        wr_en = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            lin = AW'(k);
            wr_data = pat[k];
            step();
        end
        wr_en = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            lin = AW'(k);
            #1;
            chk(lout_a, pat[k], "R8 RAM read after write");
            chk(lout_b, pat[k], "R8 far cell RAM read");
        end
        lin = AW'(5);
        wr_data = ~pat[5];
        wr_en = 1'b1;
        step();
        wr_en = 1'b0;
        pat[5] = ~pat[5];
        for (int k = 4; k < 7; k++) begin
            lin = AW'(k);
            #1;
            chk(lout_a, pat[k], "R8 single rewrite");
        end

        summary();
        $finish;
    end
endmodule